// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block collects 34 interrupt request lines and tells a small CPU-side handshake which line to service next. Each line holds a pending flag, an enable flag and a 3-bit priority, where 0 is the most urgent level and 7 the least. A global mask and a priority threshold sit above the per-line enables. Among the lines that pass every mask, an arbiter picks a winner. A request is offered to the CPU only when no handler is running, or when the winner's preempt group is strictly more urgent than the group now executing.

Software sets a grouping width M from 0 to 3. The low M bits of a priority are the subpriority and the upper 3-M bits are the preempt group. Lines that share a group never preempt each other. They are served back-to-back in full-priority order. Running handlers are held as a set of active lines, each stored with the group it had when it was accepted, so handlers can nest. A small state machine tracks the nesting depth. Its states are IDLE (no handler active), SINGLE (one active) and NESTED (two or more active). Its transitions are *first-take* (IDLE to SINGLE), *nest* (SINGLE to NESTED), *unwind* (NESTED to SINGLE), *finish* (SINGLE to IDLE) and *swap* (a return and an accept in the same cycle, which keeps SINGLE).

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset every pending, enable and active bit is clear, all priorities are 0, the global mask and the threshold are off and M is 0, so `req_valid` and `act_valid` are low.
- R2: A line's pending bit sets on a rising edge of its `irq_in` bit, one clock later, and a level held high does not set it again. The write op 3 (`cfg_idx` = line) sets a pending bit and op 4 clears it. `pend_bits` shows all pending bits.
- R3: Op 1 writes a line's enable from `cfg_wdata[0]`. Op 5 with `cfg_wdata[0]`=1 masks every line globally and with 0 unmasks. Global masking leaves the per-line enables unchanged, so a masked request comes back when unmasking.
- R4: Op 6 writes the threshold T from `cfg_wdata`. With T=0 nothing is masked. Otherwise a line with priority >= T is not eligible.
- R5: Op 2 writes a line's priority from `cfg_wdata`. Among the eligible lines the lowest full priority wins. On a tie the lowest line number wins, and `req_line` names the winner.
- R6: Op 7 writes M from `cfg_wdata[1:0]`, and the group is the priority shifted right by M. `req_valid` is high when a winner exists and either no handler is active or the winner's group is strictly below the current execution group.
- R7: `cpu_accept` takes effect only in a cycle with `req_valid` high. On that edge the winner becomes active and its pending bit clears.
- R8: The current handler is the active line with the most urgent stored group, reported on `act_valid`/`act_line`. `cpu_return` deactivates it and has no effect while nothing is active.
- R9: A pending line whose group is not strictly more urgent waits. After the return it is offered back-to-back, ahead of same-group lines with a worse subpriority.
- R10: `act_nested` is high exactly when two or more handlers are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 34 | Interrupt request lines, latched on rising edge |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 3 | Operation: 0 none, 1 enable, 2 priority, 3 set pending, 4 clear pending, 5 global mask, 6 threshold, 7 grouping |
| cfg_idx | input | 6 | Target line for per-line operations |
| cfg_wdata | input | 3 | Write value |
| pend_bits | output | 34 | All pending bits |
| req_valid | output | 1 | A line may be taken now |
| req_line | output | 6 | Winning line number |
| cpu_accept | input | 1 | CPU takes the offered line |
| cpu_return | input | 1 | Current handler returns |
| act_valid | output | 1 | At least one handler active |
| act_line | output | 6 | Line of the current handler |
| act_nested | output | 1 | Two or more handlers active |

## Verification
A corrupted active set or stored group would show up in two ways at the ports. The bench would see a request offered or held back wrongly, or `act_line` would fail to fall back to the interrupted line after a return. Either fault is visible in the cycle after the offending accept or return. The bench sweeps every grouping width against every pair of running and arriving priorities, and compares `req_valid`, the unwind order and `act_nested` with values computed from the group arithmetic. It also sweeps every threshold against every priority. A stale pending bit would appear on `pend_bits` one cycle after the accept or the clear.

// File: rtl/nic_pkg.sv
package nic_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_EN     = 3'd1,
        OP_PRIO   = 3'd2,
        OP_PSET   = 3'd3,
        OP_PCLR   = 3'd4,
        OP_GMASK  = 3'd5,
        OP_THRESH = 3'd6,
        OP_GROUP  = 3'd7
    } cfg_op_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SINGLE = 2'd1,
        S_NESTED = 2'd2
    } exec_state_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N = 34
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] sw_clr,
    input  logic [N-1:0] acc_clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] prev_q;
    logic [N-1:0] edge_hit;

    assign edge_hit = irq_in & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend   <= '0;
        end else begin
            prev_q <= irq_in;
            pend   <= (pend & ~sw_clr & ~acc_clr) | edge_hit | sw_set;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_in[i] && !prev_q[i]) |=> pend[i]);
        a_r7_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_clr[i] && !edge_hit[i] && !sw_set[i]) |=> !pend[i]);
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int N  = 34,
    parameter int PW = 3,
    parameter int IW = 6
) (
    input  logic [N-1:0]         elig,
    input  logic [N-1:0][PW-1:0] prio,
    output logic                 win_valid,
    output logic [IW-1:0]        win_line,
    output logic [PW-1:0]        win_prio
);
    always_comb begin
        win_valid = 1'b0;
        win_line  = '0;
        win_prio  = '1;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!win_valid || prio[i] < win_prio)) begin
                win_valid = 1'b1;
                win_line  = IW'(i);
                win_prio  = prio[i];
            end
        end
    end
endmodule

// File: rtl/irq_active_track.sv
module irq_active_track
    import nic_pkg::*;
#(
    parameter int N  = 34,
    parameter int PW = 3,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_fire,
    input  logic [IW-1:0] acc_line,
    input  logic [PW-1:0] acc_grp,
    input  logic          ret,
    output logic          act_valid,
    output logic [IW-1:0] act_line,
    output logic [PW-1:0] exec_grp,
    output logic          nested
);
    localparam int CW = $clog2(N + 1);

    exec_state_e           state_q, state_d;
    logic [N-1:0]          act_q, act_d;
    logic [N-1:0][PW-1:0]  grp_q;
    logic [IW-1:0]         cur_line;
    logic [PW-1:0]         cur_grp;
    logic                  cur_any;
    logic [CW-1:0]         cnt_d;

    // current handler: most urgent stored group, ties to lowest line
    always_comb begin
        cur_any  = 1'b0;
        cur_line = '0;
        cur_grp  = '1;
        for (int i = 0; i < N; i++) begin
            if (act_q[i] && (!cur_any || grp_q[i] < cur_grp)) begin
                cur_any  = 1'b1;
                cur_line = IW'(i);
                cur_grp  = grp_q[i];
            end
        end
    end

    always_comb begin
        act_d = act_q;
        if (ret && cur_any) act_d[cur_line] = 1'b0;
        if (acc_fire) act_d[acc_line] = 1'b1;
        cnt_d = CW'($countones(act_d));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
            grp_q <= '0;
        end else begin
            act_q <= act_d;
            if (acc_fire) grp_q[acc_line] <= acc_grp;
        end
    end

    // next-state: first-take, nest, unwind, finish, swap
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (cnt_d != 0) state_d = S_SINGLE;
            S_SINGLE: if (cnt_d == 0) state_d = S_IDLE;
                      else if (cnt_d > 1) state_d = S_NESTED;
            S_NESTED: if (cnt_d == 1) state_d = S_SINGLE;
                      else if (cnt_d == 0) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        act_valid = (state_q != S_IDLE);
        nested    = (state_q == S_NESTED);
        act_line  = cur_line;
        exec_grp  = cur_grp;
    end

    a_r1_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> (act_q == '0));
    a_r6_preempt_strict: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fire && state_q != S_IDLE) |-> (acc_grp < cur_grp));
    a_r8_return_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && state_q != S_IDLE && !acc_fire) |=> !act_q[$past(cur_line)]);
    a_r10_nested_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_NESTED) |-> ($countones(act_q) >= 2));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NUM_LINES = 34,
    parameter int PRIO_W    = 3,
    localparam int IW       = $clog2(NUM_LINES),
    localparam int MW       = $clog2(PRIO_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_op,
    input  logic [IW-1:0]        cfg_idx,
    input  logic [PRIO_W-1:0]    cfg_wdata,
    output logic [NUM_LINES-1:0] pend_bits,
    output logic                 req_valid,
    output logic [IW-1:0]        req_line,
    input  logic                 cpu_accept,
    input  logic                 cpu_return,
    output logic                 act_valid,
    output logic [IW-1:0]        act_line,
    output logic                 act_nested
);
    localparam logic [NUM_LINES-1:0] ONE = {{(NUM_LINES-1){1'b0}}, 1'b1};

    logic [NUM_LINES-1:0]             en_q;
    logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q;
    logic                             gmask_q;
    logic [PRIO_W-1:0]                thresh_q;
    logic [MW-1:0]                    mgrp_q;

    logic                 idx_ok;
    logic [NUM_LINES-1:0] sel_vec, sw_set, sw_clr, acc_clr, elig;
    logic                 win_valid, acc_fire;
    logic [IW-1:0]        win_line;
    logic [PRIO_W-1:0]    win_prio, win_grp, exec_grp;

    assign idx_ok  = (int'(cfg_idx) < NUM_LINES);
    assign sel_vec = idx_ok ? (ONE << cfg_idx) : '0;
    assign sw_set  = (cfg_we && cfg_op_e'(cfg_op) == OP_PSET) ? sel_vec : '0;
    assign sw_clr  = (cfg_we && cfg_op_e'(cfg_op) == OP_PCLR) ? sel_vec : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            prio_q   <= '0;
            gmask_q  <= 1'b0;
            thresh_q <= '0;
            mgrp_q   <= '0;
        end else if (cfg_we) begin
            unique case (cfg_op_e'(cfg_op))
                OP_EN:     if (idx_ok) en_q[cfg_idx] <= cfg_wdata[0];
                OP_PRIO:   if (idx_ok) prio_q[cfg_idx] <= cfg_wdata;
                OP_GMASK:  gmask_q  <= cfg_wdata[0];
                OP_THRESH: thresh_q <= cfg_wdata;
                OP_GROUP:  mgrp_q   <= (int'(cfg_wdata[1:0]) > PRIO_W) ?
                                       MW'(PRIO_W) : MW'(cfg_wdata[1:0]);
                default:   ;
            endcase
        end
    end

    irq_pend_bank #(.N(NUM_LINES)) u_pend (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .sw_set(sw_set),
        .sw_clr(sw_clr), .acc_clr(acc_clr), .pend(pend_bits)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_elig
        assign elig[i] = pend_bits[i] && en_q[i] && !gmask_q &&
                         ((thresh_q == '0) || (prio_q[i] < thresh_q));
    end

    irq_arbiter #(.N(NUM_LINES), .PW(PRIO_W), .IW(IW)) u_arb (
        .elig(elig), .prio(prio_q), .win_valid(win_valid),
        .win_line(win_line), .win_prio(win_prio)
    );

    assign win_grp   = win_prio >> mgrp_q;
    assign req_valid = win_valid && (!act_valid || win_grp < exec_grp);
    assign req_line  = win_line;
    assign acc_fire  = cpu_accept && req_valid;
    assign acc_clr   = acc_fire ? (ONE << win_line) : '0;

    irq_active_track #(.N(NUM_LINES), .PW(PRIO_W), .IW(IW)) u_act (
        .clk(clk), .rst_n(rst_n), .acc_fire(acc_fire), .acc_line(win_line),
        .acc_grp(win_grp), .ret(cpu_return), .act_valid(act_valid),
        .act_line(act_line), .exec_grp(exec_grp), .nested(act_nested)
    );

    a_r3_req_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (en_q[req_line] && !gmask_q && pend_bits[req_line]));
    a_r4_req_under_thresh: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && thresh_q != '0) |-> (prio_q[req_line] < thresh_q));
    a_r7_accept_activates: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_accept && req_valid) |=> act_valid);
endmodule

// File: tb/nest_irq_ctrl_tb.sv
`timescale 1ns/1ps
module nest_irq_ctrl_tb;
    localparam int N = 34;
    localparam logic [2:0] OP_EN = 3'd1, OP_PRIO = 3'd2, OP_PSET = 3'd3,
        OP_PCLR = 3'd4, OP_GMASK = 3'd5, OP_THRESH = 3'd6, OP_GROUP = 3'd7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_op = '0, cfg_wdata = '0;
    logic [5:0] cfg_idx = '0;
    logic [N-1:0] pend_bits;
    logic req_valid, act_valid, act_nested;
    logic [5:0] req_line, act_line;
    logic cpu_accept = 1'b0, cpu_return = 1'b0;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    nest_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
        .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .pend_bits(pend_bits), .req_valid(req_valid), .req_line(req_line),
        .cpu_accept(cpu_accept), .cpu_return(cpu_return),
        .act_valid(act_valid), .act_line(act_line), .act_nested(act_nested)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_in = '0; cfg_we = 0; cpu_accept = 0; cpu_return = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] op, input int idx, input int d);
        cfg_we = 1'b1; cfg_op = op; cfg_idx = 6'(idx); cfg_wdata = 3'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic accept();
        cpu_accept = 1'b1; @(negedge clk); cpu_accept = 1'b0;
    endtask

    task automatic ret();
        cpu_return = 1'b1; @(negedge clk); cpu_return = 1'b0;
    endtask

    task automatic raise(input int l);
        irq_in[l] = 1'b1; @(negedge clk);
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        chk_eq("R1 pend_bits", int'(pend_bits != 0), 0);
        chk_eq("R1 req_valid", int'(req_valid), 0);
        chk_eq("R1 act_valid", int'(act_valid), 0);

        // R6 R8 R9 R10: sweep grouping width against running/arriving priorities
        for (int m = 0; m < 4; m++)
            for (int pa = 0; pa < 8; pa++)
                for (int pb = 0; pb < 8; pb++) begin
                    bit pre;
                    do_reset();
                    wr(OP_GROUP, 0, m);
                    wr(OP_PRIO, 5, pa); wr(OP_PRIO, 20, pb);
                    wr(OP_EN, 5, 1); wr(OP_EN, 20, 1);
                    raise(5);
                    chk_eq("R6 idle offer line", int'(req_valid) * 100 + int'(req_line), 105);
                    accept();
                    chk_eq("R7 running line", int'(act_line), 5);
                    raise(20);
                    pre = ((pb >> m) < (pa >> m));
                    chk_eq("R6 preempt decision", int'(req_valid), int'(pre));
                    if (pre) begin
                        accept();
                        chk_eq("R10 nested", int'(act_nested) * 100 + int'(act_line), 120);
                        ret();
                        chk_eq("R8 unwind to line", int'(act_line), 5);
                        chk_eq("R10 single", int'(act_nested), 0);
                        ret();
                        chk_eq("R8 finish", int'(act_valid), 0);
                    end else begin
                        ret();
                        chk_eq("R9 back-to-back", int'(req_valid) * 100 + int'(req_line), 120);
                        accept(); ret();
                    end
                end

        // R4 threshold sweep
        for (int t = 0; t < 8; t++)
            for (int p = 0; p < 8; p++) begin
                do_reset();
                wr(OP_PRIO, 7, p); wr(OP_EN, 7, 1); wr(OP_THRESH, 0, t); wr(OP_PSET, 7, 0);
                chk_eq("R4 threshold", int'(req_valid), int'(t == 0 || p < t));
            end

        // R5 tie and priority winner
        do_reset();
        wr(OP_PRIO, 3, 4); wr(OP_PRIO, 33, 4); wr(OP_EN, 3, 1); wr(OP_EN, 33, 1);
        wr(OP_PSET, 33, 0); wr(OP_PSET, 3, 0);
        chk_eq("R5 tie lowest line", int'(req_line), 3);
        wr(OP_PRIO, 33, 1);
        chk_eq("R5 urgent wins", int'(req_line), 33);

        // R3 global mask preserves enables
        do_reset();
        wr(OP_EN, 9, 1); wr(OP_PSET, 9, 0);
        wr(OP_GMASK, 0, 1);
        chk_eq("R3 global mask blocks", int'(req_valid), 0);
        wr(OP_GMASK, 0, 0);
        chk_eq("R3 unmask restores", int'(req_valid) * 100 + int'(req_line), 109);
        wr(OP_EN, 9, 0);
        chk_eq("R3 line disable", int'(req_valid), 0);
        chk_eq("R3 pend kept", int'(pend_bits[9]), 1);

        // R2 edge latch, level no relatch, software clear
        do_reset();
        wr(OP_EN, 2, 1);
        raise(2);
        chk_eq("R2 edge latch", int'(pend_bits[2]), 1);
        accept();
        chk_eq("R7 pend cleared", int'(pend_bits[2]), 0);
        ret();
        chk_eq("R2 level no relatch", int'(pend_bits[2]) + int'(req_valid), 0);
        irq_in[2] = 1'b0; @(negedge clk);
        raise(2);
        chk_eq("R2 second edge", int'(pend_bits[2]), 1);
        wr(OP_PCLR, 2, 0);
        chk_eq("R2 sw clear", int'(pend_bits[2]), 0);

        // R7 accept ignored without request; R8 return ignored when idle
        do_reset();
        wr(OP_PSET, 4, 0);
        accept();
        chk_eq("R7 accept ignored", int'(act_valid) * 10 + int'(pend_bits[4]), 1);
        ret();
        chk_eq("R8 idle return", int'(act_valid), 0);

        // R9 subpriority order after return
        do_reset();
        wr(OP_GROUP, 0, 1);
        wr(OP_PRIO, 0, 0); wr(OP_PRIO, 10, 2); wr(OP_PRIO, 30, 3);
        wr(OP_EN, 0, 1); wr(OP_EN, 10, 1); wr(OP_EN, 30, 1);
        wr(OP_PSET, 0, 0); accept();
        wr(OP_PSET, 30, 0); wr(OP_PSET, 10, 0);
        chk_eq("R9 waits", int'(req_valid), 0);
        ret();
        chk_eq("R9 subpriority first", int'(req_valid) * 100 + int'(req_line), 110);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule